// File: doc/BRIEF.md
# Paired Interrupt Status Aggregator

This block keeps one 8-bit interrupt status register and one 8-bit mask register for each of four groups. Each group serves two adjacent serial channels. Per-channel event requests (transmit ready, receive ready, break) and per-group auxiliary events (counter ready, input change) set and clear the status bits. The masked status of two neighbouring groups is merged onto one shared, level-sensitive interrupt line, which gives two lines in total.

Software reaches the block through three byte-wide access paths:
- An I/O path reads a group's status and loads a group's mask. Its 8-bit address is split into group, channel and register offset.
- An identification-space path loads the programmable interrupt vector.
- An acknowledge path returns that vector to the interrupt handler that is serving one of the two lines.

Top module: `irq_pair_agg`

## Requirements
- R1: Channel n belongs to group n/2. Each channel has a 3-bit request vector at positions 3n+0, 3n+1 and 3n+2 of `evtSet` and `evtClr`, for transmit ready, receive ready and break. These requests act on group status bits 0, 1 and 2 for an even channel and on bits 4, 5 and 6 for an odd channel.
- R2: Group g's counter-ready flag is status bit 3, driven by `auxSet[2g]` and `auxClr[2g]`. Its input-change flag is status bit 7, driven by `auxSet[2g+1]` and `auxClr[2g+1]`.
- R3: A set request makes its status bit 1 at the next clock edge. A clear request alone makes it 0. When set and clear arrive in the same cycle, set wins. With neither request, the bit holds.
- R4: Line 0 covers groups 0 and 1, and line 1 covers groups 2 and 3. In every cycle, a line is 1 exactly when status AND mask is non-zero in either of its groups. The line reflects a status or mask change at the same clock edge that stores that change.
- R5: An I/O write whose register offset is 0x0B loads `ioWrData` into the mask of the group chosen by address bits 7..6, at the next edge. Writes at other offsets change no mask.
- R6: An I/O read at offset 0x0B returns that group's status on `ioRdData` in the same cycle. Any other read, and any cycle without a read, returns 0.
- R7: The decode outputs give the group as address bits 7..6 and the channel as bits 7..5. The register offset is address bits 4..0 XOR 1.
- R8: An identification write at address 1 loads `idWrData` into the vector at the next edge. Identification writes at other addresses leave the vector unchanged.
- R9: An acknowledge read at address 0 or address 2 returns the vector on `ackData` in the same cycle. Every other acknowledge address returns 0. An acknowledge never changes status, mask or lines.
- R10: Reset clears all status, mask, vector and line state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtSet | input | 24 | Per-channel set requests, 3 per channel |
| evtClr | input | 24 | Per-channel clear requests, 3 per channel |
| auxSet | input | 8 | Per-group counter-ready / input-change set requests |
| auxClr | input | 8 | Per-group counter-ready / input-change clear requests |
| ioAddr | input | 8 | I/O byte address |
| ioWrEn | input | 1 | I/O write strobe |
| ioWrData | input | 8 | I/O write data |
| ioRdEn | input | 1 | I/O read strobe |
| ioRdData | output | 8 | I/O read data (combinational) |
| decGroup | output | 2 | Decoded group index |
| decChan | output | 3 | Decoded channel index |
| decOffset | output | 5 | Decoded register offset |
| idWrEn | input | 1 | Identification-space write strobe |
| idAddr | input | 8 | Identification-space address |
| idWrData | input | 8 | Identification-space write data |
| ackRdEn | input | 1 | Acknowledge read strobe |
| ackAddr | input | 8 | Acknowledge address |
| ackData | output | 8 | Acknowledge read data (combinational) |
| irqLine | output | 2 | Level interrupt lines |

## Verification
Read data, acknowledge data and the decode outputs are combinational. The bench therefore samples them shortly after driving its inputs on the falling edge, before the next rising edge. Status, mask, vector and both lines are registered and are due one rising edge after the request. The bench updates its model right after that edge and compares the lines on the following falling edge. Status is observed only through group reads, so the bench issues a full readback of all four groups at regular intervals and after each directed case.

// File: rtl/irq_pair_agg_pkg.sv
package irq_pair_agg_pkg;
  localparam int GROUPS      = 4;
  localparam int CH_PER_GRP  = 2;
  localparam int CHANS       = GROUPS * CH_PER_GRP;
  localparam int GRP_PER_LN  = 2;
  localparam int LINES       = GROUPS / GRP_PER_LN;
  localparam int EVT_PER_CH  = 3;
  localparam int AUX_PER_GRP = 2;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int GIDX_W      = $clog2(GROUPS);
  localparam int CIDX_W      = $clog2(CHANS);
  localparam int OFS_W       = 5;
  localparam int HALF_W      = DATA_W / 2;
  localparam int CNT_BIT     = 3;
  localparam int CHG_BIT     = 7;

  localparam logic [OFS_W-1:0]  OFS_STAT    = 5'h0B;
  localparam logic [ADDR_W-1:0] ID_VEC_ADDR = 8'h01;

  typedef struct packed {
    logic              maskWr;
    logic              statRd;
    logic              vecWr;
    logic              ackHit;
    logic [GIDX_W-1:0] grp;
  } strobe_t;
endpackage

// File: rtl/irq_pair_agg_ctrl.sv
module irq_pair_agg_ctrl
  import irq_pair_agg_pkg::*;
(
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic              idWrEn,
  input  logic [ADDR_W-1:0] idAddr,
  input  logic              ackRdEn,
  input  logic [ADDR_W-1:0] ackAddr,
  output strobe_t           strb,
  output logic [GIDX_W-1:0] decGroup,
  output logic [CIDX_W-1:0] decChan,
  output logic [OFS_W-1:0]  decOffset
);
  logic ackValidAddr;

  assign decGroup  = ioAddr[ADDR_W-1 -: GIDX_W];
  assign decChan   = ioAddr[ADDR_W-1 -: CIDX_W];
  assign decOffset = ioAddr[OFS_W-1:0] ^ OFS_W'(1);

  // Even acknowledge addresses 0, 2, ... each serve one line
  always_comb begin
    ackValidAddr = 1'b0;
    for (int l = 0; l < LINES; l++) begin
      if (ackAddr == ADDR_W'(2 * l)) ackValidAddr = 1'b1;
    end
  end

  always_comb begin
    strb.grp    = decGroup;
    strb.maskWr = ioWrEn && (decOffset == OFS_STAT);
    strb.statRd = ioRdEn && (decOffset == OFS_STAT);
    strb.vecWr  = idWrEn && (idAddr == ID_VEC_ADDR);
    strb.ackHit = ackRdEn && ackValidAddr;
  end
endmodule

// File: rtl/irq_pair_agg_dp.sv
module irq_pair_agg_dp
  import irq_pair_agg_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  strobe_t                              strb,
  input  logic [CHANS*EVT_PER_CH-1:0]          evtSet,
  input  logic [CHANS*EVT_PER_CH-1:0]          evtClr,
  input  logic [GROUPS*AUX_PER_GRP-1:0]        auxSet,
  input  logic [GROUPS*AUX_PER_GRP-1:0]        auxClr,
  input  logic [DATA_W-1:0]                    ioWrData,
  input  logic [DATA_W-1:0]                    idWrData,
  output logic [GROUPS-1:0][DATA_W-1:0]        statusVec,
  output logic [GROUPS-1:0][DATA_W-1:0]        maskVec,
  output logic [DATA_W-1:0]                    vecQ,
  output logic [LINES-1:0]                     irqLine,
  output logic [DATA_W-1:0]                    ioRdData,
  output logic [DATA_W-1:0]                    ackData
);
  logic [GROUPS-1:0][DATA_W-1:0] setMap, clrMap, statNext, maskNext;

  // Scatter channel and auxiliary requests into status bit positions
  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      setMap[g] = '0;
      clrMap[g] = '0;
      for (int k = 0; k < CH_PER_GRP; k++) begin
        for (int b = 0; b < EVT_PER_CH; b++) begin
          setMap[g][k*HALF_W+b] = evtSet[(g*CH_PER_GRP+k)*EVT_PER_CH+b];
          clrMap[g][k*HALF_W+b] = evtClr[(g*CH_PER_GRP+k)*EVT_PER_CH+b];
        end
      end
      setMap[g][CNT_BIT] = auxSet[g*AUX_PER_GRP];
      clrMap[g][CNT_BIT] = auxClr[g*AUX_PER_GRP];
      setMap[g][CHG_BIT] = auxSet[g*AUX_PER_GRP+1];
      clrMap[g][CHG_BIT] = auxClr[g*AUX_PER_GRP+1];
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    assign statNext[g] = (statusVec[g] & ~clrMap[g]) | setMap[g];
    assign maskNext[g] = (strb.maskWr && strb.grp == GIDX_W'(g)) ? ioWrData : maskVec[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        statusVec[g] <= '0;
        maskVec[g]   <= '0;
      end else begin
        statusVec[g] <= statNext[g];
        maskVec[g]   <= maskNext[g];
      end
    end
  end

  // Lines follow the next-state values so they move with the registers
  for (genvar l = 0; l < LINES; l++) begin : gLine
    logic lineNext;
    always_comb begin
      lineNext = 1'b0;
      for (int j = 0; j < GRP_PER_LN; j++) begin
        lineNext = lineNext | (|(statNext[l*GRP_PER_LN+j] & maskNext[l*GRP_PER_LN+j]));
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) irqLine[l] <= 1'b0;
      else        irqLine[l] <= lineNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          vecQ <= '0;
    else if (strb.vecWr) vecQ <= idWrData;
  end

  assign ioRdData = strb.statRd ? statusVec[strb.grp] : '0;
  assign ackData  = strb.ackHit ? vecQ : '0;
endmodule

// File: rtl/irq_pair_agg.sv
module irq_pair_agg
  import irq_pair_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] evtSet,
  input  logic [23:0] evtClr,
  input  logic [7:0]  auxSet,
  input  logic [7:0]  auxClr,
  input  logic [7:0]  ioAddr,
  input  logic        ioWrEn,
  input  logic [7:0]  ioWrData,
  input  logic        ioRdEn,
  output logic [7:0]  ioRdData,
  output logic [1:0]  decGroup,
  output logic [2:0]  decChan,
  output logic [4:0]  decOffset,
  input  logic        idWrEn,
  input  logic [7:0]  idAddr,
  input  logic [7:0]  idWrData,
  input  logic        ackRdEn,
  input  logic [7:0]  ackAddr,
  output logic [7:0]  ackData,
  output logic [1:0]  irqLine
);
  strobe_t                       strb;
  logic [GROUPS-1:0][DATA_W-1:0] statusVec;
  logic [GROUPS-1:0][DATA_W-1:0] maskVec;
  logic [DATA_W-1:0]             vecQ;

  irq_pair_agg_ctrl u_ctrl (
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .idWrEn(idWrEn), .idAddr(idAddr),
    .ackRdEn(ackRdEn), .ackAddr(ackAddr),
    .strb(strb), .decGroup(decGroup), .decChan(decChan), .decOffset(decOffset)
  );

  irq_pair_agg_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .evtSet(evtSet), .evtClr(evtClr), .auxSet(auxSet), .auxClr(auxClr),
    .ioWrData(ioWrData), .idWrData(idWrData),
    .statusVec(statusVec), .maskVec(maskVec), .vecQ(vecQ),
    .irqLine(irqLine), .ioRdData(ioRdData), .ackData(ackData)
  );
endmodule

// File: rtl/irq_pair_agg_chk.sv
module irq_pair_agg_chk (
  input logic            clk,
  input logic            rst_n,
  input logic [23:0]     evtSet,
  input logic [7:0]      auxSet,
  input logic [7:0]      ioAddr,
  input logic            ioWrEn,
  input logic [7:0]      ioWrData,
  input logic            idWrEn,
  input logic [7:0]      idAddr,
  input logic [7:0]      idWrData,
  input logic            ackRdEn,
  input logic [7:0]      ackAddr,
  input logic [7:0]      ackData,
  input logic [1:0]      irqLine,
  input logic [3:0][7:0] statusVec,
  input logic [3:0][7:0] maskVec,
  input logic [7:0]      vecQ
);
  AST_LINE0_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irqLine[0] == |((statusVec[0] & maskVec[0]) | (statusVec[1] & maskVec[1]))); // R4
  AST_LINE1_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irqLine[1] == |((statusVec[2] & maskVec[2]) | (statusVec[3] & maskVec[3]))); // R4
  AST_EVEN_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evtSet[0] |=> statusVec[0][0]); // R3
  AST_ODD_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evtSet[4] |=> statusVec[0][5]); // R1
  AST_CNT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    auxSet[0] |=> statusVec[0][3]); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ioWrEn && ioAddr == 8'h0A) |=> maskVec[0] == $past(ioWrData)); // R5
  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (idWrEn && idAddr == 8'h01) |=> vecQ == $past(idWrData)); // R8
  AST_ACK_ODD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ackRdEn && ackAddr[0]) |-> ackData == 8'h00); // R9
  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ackRdEn && ackAddr == 8'h00) |-> ackData == vecQ); // R9
endmodule

bind irq_pair_agg irq_pair_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evtSet(evtSet), .auxSet(auxSet),
  .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
  .idWrEn(idWrEn), .idAddr(idAddr), .idWrData(idWrData),
  .ackRdEn(ackRdEn), .ackAddr(ackAddr), .ackData(ackData),
  .irqLine(irqLine), .statusVec(statusVec), .maskVec(maskVec), .vecQ(vecQ)
);

// File: tb/irq_pair_agg_test.sv
module irq_pair_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evtSet = '0, evtClr = '0;
  logic [7:0]  auxSet = '0, auxClr = '0;
  logic [7:0]  ioAddr = '0, ioWrData = '0, idAddr = '0, idWrData = '0, ackAddr = '0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0, idWrEn = 1'b0, ackRdEn = 1'b0;
  logic [7:0]  ioRdData, ackData;
  logic [1:0]  decGroup, irqLine;
  logic [2:0]  decChan;
  logic [4:0]  decOffset;

  logic [7:0] expStat [4];
  logic [7:0] expMask [4];
  logic [7:0] expVec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_pair_agg uut (.*);

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead();
    if (ioRdEn && ((ioAddr[4:0] ^ 5'h01) == 5'h0B)) return expStat[ioAddr[7:6]];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expAck();
    if (ackRdEn && (ackAddr == 8'h00 || ackAddr == 8'h02)) return expVec;
    return 8'h00;
  endfunction

  function automatic logic expLine(int l);
    return |((expStat[2*l] & expMask[2*l]) | (expStat[2*l+1] & expMask[2*l+1]));
  endfunction

  task automatic updateModel();
    for (int c = 0; c < 8; c++) begin
      int g = c / 2;
      int base = (c % 2 == 1) ? 4 : 0;
      for (int b = 0; b < 3; b++) begin
        if (evtSet[c*3+b])      expStat[g][base+b] = 1'b1;
        else if (evtClr[c*3+b]) expStat[g][base+b] = 1'b0;
      end
    end
    for (int g = 0; g < 4; g++) begin
      if (auxSet[2*g])        expStat[g][3] = 1'b1;
      else if (auxClr[2*g])   expStat[g][3] = 1'b0;
      if (auxSet[2*g+1])      expStat[g][7] = 1'b1;
      else if (auxClr[2*g+1]) expStat[g][7] = 1'b0;
    end
    if (ioWrEn && ((ioAddr[4:0] ^ 5'h01) == 5'h0B)) expMask[ioAddr[7:6]] = ioWrData;
    if (idWrEn && idAddr == 8'h01) expVec = idWrData;
  endtask

  task automatic idle();
    evtSet = '0; evtClr = '0; auxSet = '0; auxClr = '0;
    ioWrEn = 0; ioRdEn = 0; idWrEn = 0; ackRdEn = 0;
    ioAddr = '0; ioWrData = '0; idAddr = '0; idWrData = '0; ackAddr = '0;
  endtask

  // Inputs are driven at a falling edge before this call
  task automatic step(string lineTag, string ackTag);
    #1;
    check("R7 group", decGroup, ioAddr[7:6]);
    check("R7 chan", decChan, ioAddr[7:5]);
    check("R7 offset", decOffset, ioAddr[4:0] ^ 5'h01);
    check("R6 read", ioRdData, expRead());
    check(ackTag, ackData, expAck());
    @(posedge clk);
    updateModel();
    @(negedge clk);
    check(lineTag, irqLine[0], expLine(0));
    check(lineTag, irqLine[1], expLine(1));
  endtask

  task automatic readback(string tag);
    for (int g = 0; g < 4; g++) begin
      idle();
      ioRdEn = 1;
      ioAddr = 8'(g * 64 + 8'h0A);
      #1;
      check(tag, ioRdData, expStat[g]);
      @(negedge clk);
    end
    idle();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int g = 0; g < 4; g++) begin expStat[g] = '0; expMask[g] = '0; end
    expVec = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: everything zero after reset
    check("R10 line0", irqLine[0], 0);
    check("R10 line1", irqLine[1], 0);
    ackRdEn = 1; ackAddr = 8'h00; #1;
    check("R10 vector", ackData, 0);
    @(negedge clk);
    readback("R10 status");

    // R1: odd channel 3 break -> group 1 bit 6; even channel 4 rx -> group 2 bit 1
    idle(); evtSet[3*3+2] = 1; evtSet[4*3+1] = 1; step("R4", "R9");
    idle(); readback("R1");

    // R2: group 3 input-change (bit 7) and group 0 counter-ready (bit 3)
    idle(); auxSet[7] = 1; auxSet[0] = 1; step("R4", "R9");
    idle(); readback("R2");

    // R3: set and clear together on channel 0 tx, then clear only on channel 3 break
    idle(); evtSet[0] = 1; evtClr[0] = 1; evtClr[3*3+2] = 1; step("R4", "R9");
    idle(); readback("R3");

    // R5: mask group 1 bit 6 -> line 0; group 2 mask with unrelated bits -> line 1 low
    idle(); ioWrEn = 1; ioAddr = 8'h4A; ioWrData = 8'h40; step("R5", "R9");
    idle(); ioWrEn = 1; ioAddr = 8'h8A; ioWrData = 8'hFD; step("R5", "R9");
    idle(); ioWrEn = 1; ioAddr = 8'h8B; ioWrData = 8'hFF; step("R5", "R9");
    idle(); ioWrEn = 1; ioAddr = 8'hCA; ioWrData = 8'h80; step("R5", "R9");
    idle(); evtClr[3*3+2] = 1; step("R4", "R9");

    // R8: ID writes at other addresses ignored, address 1 loads
    idle(); idWrEn = 1; idAddr = 8'h00; idWrData = 8'h5A; step("R4", "R9");
    idle(); ackRdEn = 1; ackAddr = 8'h00; step("R4", "R8");
    idle(); idWrEn = 1; idAddr = 8'h01; idWrData = 8'hC3; step("R4", "R9");
    // R9: addresses 0 and 2 return vector, 1 and 3 return zero, no side effects
    for (int a = 0; a < 4; a++) begin
      idle(); ackRdEn = 1; ackAddr = 8'(a); step("R9 line", "R9");
    end
    idle(); readback("R9 status");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      idle();
      evtSet = 24'($urandom & $urandom & $urandom);
      evtClr = 24'($urandom & $urandom);
      auxSet = 8'($urandom & $urandom & $urandom);
      auxClr = 8'($urandom & $urandom);
      ioWrEn = ($urandom % 4) == 0;
      ioRdEn = ($urandom % 2) == 0;
      ioAddr = ($urandom % 2) ? {2'($urandom), 1'($urandom), 5'h0A} : 8'($urandom);
      ioWrData = 8'($urandom);
      idWrEn = ($urandom % 8) == 0;
      idAddr = 8'($urandom % 4);
      idWrData = 8'($urandom);
      ackRdEn = ($urandom % 2) == 0;
      ackAddr = 8'($urandom % 5);
      step("R4", "R9");
      if (i % 20 == 19) readback("R6 status");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule